// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block runs the digital half of a successive-approximation analog-to-digital converter. It drives a trial code into an external DAC and reads back a single comparator decision. It then narrows the code by binary search, resolving one bit per clock from the most significant bit down to bit 0. When the least significant bit is resolved, the final code is latched into a result register and a one-cycle done pulse is issued.

A hold output stays asserted for the whole conversion, so an external sample-and-hold keeps the analog input frozen while the search runs. The comparator input is high when the held input voltage is above the voltage the DAC produces for the current trial code. Each trial code sits on the DAC output for one full clock before the comparator is sampled. A conversion of `WIDTH` bits therefore takes `WIDTH` clocks. Start, hold, busy and done are plain control pins with no handshake.

Top module: `sar_search_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `busy_o`, `hold_o` and `done_o` are 0, and `dac_code_o` and `result_o` are all zeros.
- R2: When `start_i` is high at a rising edge while idle, then from that edge on `busy_o` and `hold_o` are 1 and `dac_code_o` holds only its most significant bit set (128 for `WIDTH`=8).
- R3: At each following edge, the bit under trial takes the value of `cmp_hi_i` (1 keeps it, 0 clears it). The next lower bit is set to 1 at the same edge, and bits already decided do not change.
- R4: `done_o` is high in the cycle that starts exactly `WIDTH` clocks after the accepting edge. `busy_o` is high for exactly `WIDTH` cycles.
- R5: With a comparator that reports `target >= dac_code_o`, `result_o` equals `target` for every code from 0 to 2^`WIDTH`-1.
- R6: `hold_o` is high over the same cycles as `busy_o`, and it is low when `done_o` is high.
- R7: `done_o` is high for a single cycle, and `result_o` changes only at the edge that raises `done_o`.
- R8: `start_i` pulses while `busy_o` is high have no effect on the trial codes, the done timing or the result.
- R9: While idle, `dac_code_o` shows the last result (all zeros after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a conversion; taken only while idle |
| cmp_hi_i | input | 1 | Comparator: 1 when the held input is above the DAC output |
| dac_code_o | output | WIDTH | Trial code driven to the external DAC |
| hold_o | output | 1 | Sample-and-hold freeze, high during a conversion |
| busy_o | output | 1 | High while a conversion is in progress |
| result_o | output | WIDTH | Code from the most recent finished conversion |
| done_o | output | 1 | One-cycle pulse when a new result is latched |

## Verification
The bench builds the controller at its default `WIDTH` of 8. At that width, all 256 target codes can be run through a bench comparator model, and every intermediate trial code of every search can be checked against the code worked out from the target's upper bits. This exercises the extreme codes 0 and 255 and every keep/clear pattern. Start pulses are also injected in the middle of half of the conversions, to show that a busy converter ignores them.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    SAR_IDLE = 1'b0,
    SAR_CONV = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
  import sar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic last_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  sar_state_e state_q, state_d;
  logic       done_q;

  assign load_o = (state_q == SAR_IDLE) && start_i;
  assign step_o = (state_q == SAR_CONV);
  assign busy_o = (state_q == SAR_CONV);
  assign done_o = done_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SAR_IDLE: if (start_i) state_d = SAR_CONV;
      SAR_CONV: if (last_i)  state_d = SAR_IDLE;
      default:               state_d = SAR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SAR_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= step_o && last_i;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_i) |=> busy_o);
endmodule

// File: rtl/sar_bit_ptr.sv
module sar_bit_ptr #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  output logic [WIDTH-1:0] ptr_o,
  output logic             last_o
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (load_i) ptr_q <= TOP_BIT;
    else if (step_i) ptr_q <= ptr_q >> 1;
  end

  assign ptr_o  = ptr_q;
  assign last_o = ptr_q[0];

  // R3
  ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ptr_q));

  // R3
  ptr_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (ptr_q != '0));
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] ptr_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic [WIDTH-1:0] result_o
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] trial_q, result_q, stepped;

  // Per bit: decide the bit under trial, raise the bit just below it,
  // leave every other bit as it is.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == WIDTH-1) begin : g_top
      assign stepped[i] = ptr_i[i] ? cmp_i : trial_q[i];
    end else begin : g_low
      assign stepped[i] = ptr_i[i]   ? cmp_i :
                          ptr_i[i+1] ? 1'b1  : trial_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q  <= '0;
      result_q <= '0;
    end else if (load_i) begin
      trial_q  <= TOP_BIT;
    end else if (step_i) begin
      trial_q  <= stepped;
      if (ptr_i[0]) result_q <= stepped;
    end
  end

  assign trial_o  = trial_q;
  assign result_o = result_q;

  // R5
  result_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && ptr_i[0]) |=> (result_o == trial_o));

  // R3
  top_bit_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !ptr_i[WIDTH-1]) |=> (trial_o[WIDTH-1] == $past(trial_o[WIDTH-1])));
endmodule

// File: rtl/sar_search_ctrl.sv
module sar_search_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_hi_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             hold_o,
  output logic             busy_o,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o
);
  localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  logic             load, step, last;
  logic [WIDTH-1:0] ptr;

  sar_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .last_i  (last),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  sar_bit_ptr #(.WIDTH(WIDTH)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .step_i (step),
    .ptr_o  (ptr),
    .last_o (last)
  );

  sar_trial_reg #(.WIDTH(WIDTH)) u_trial (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .step_i   (step),
    .ptr_i    (ptr),
    .cmp_i    (cmp_hi_i),
    .trial_o  (dac_code_o),
    .result_o (result_o)
  );

  assign hold_o = busy_o;

  // R2
  first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (dac_code_o == TOP_BIT));

  // R6
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!hold_o && $past(hold_o)));

  // R9
  idle_dac_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (dac_code_o == result_o));

  // R7
  result_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));
endmodule

// File: tb/sim_sar_search_ctrl.sv
module sim_sar_search_ctrl;
  localparam int W = 8;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         cmp;
  logic [W-1:0] dac, result;
  logic         hold, busy, done;
  int           target = 0;
  int           checks = 0;
  int           errors = 0;
  bit           finished = 0;

  always #2 clk = ~clk;

  // Ideal comparator: held input sits half an LSB above target.
  assign cmp = (target >= int'(dac));

  sar_search_ctrl #(.WIDTH(W)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .cmp_hi_i   (cmp),
    .dac_code_o (dac),
    .hold_o     (hold),
    .busy_o     (busy),
    .result_o   (result),
    .done_o     (done)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d (target %0d)", req, got, exp, target);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic convert(input int tgt, input bit poke);
    int prev;
    prev   = int'(result);
    target = tgt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    // R2: first trial, hold and busy raised
    chk("R2 first code", int'(dac), N/2);
    chk("R2 busy", int'(busy), 1);
    chk("R6 hold", int'(hold), 1);
    for (int s = 1; s < W; s++) begin
      if (poke && s == 3) start = 1'b1;  // R8: request while busy
      @(negedge clk);
      start = 1'b0;
      // R3: decided top bits follow target, next bit raised
      chk("R3 trial code", int'(dac),
          (tgt & ~((1 << (W - s)) - 1)) | (1 << (W - 1 - s)));
      chk("R7 result held", int'(result), prev);
      chk("R4 no early done", int'(done), 0);
      chk("R6 hold", int'(hold), 1);
    end
    @(negedge clk);
    chk("R4 done", int'(done), 1);
    chk("R5 result", int'(result), tgt);
    chk("R4 busy low", int'(busy), 0);
    chk("R6 hold low", int'(hold), 0);
    chk("R9 idle dac", int'(dac), tgt);
    @(negedge clk);
    chk("R7 done pulse", int'(done), 0);
    chk("R7 result kept", int'(result), tgt);
    chk("R8 stays idle", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 busy", int'(busy), 0);
    chk("R1 hold", int'(hold), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 dac", int'(dac), 0);
    chk("R1 result", int'(result), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(busy) + int'(done) + int'(dac), 0);
    for (int t = 0; t < N; t++) convert(t, t[0]);
    convert(N - 1, 1'b1);
    convert(0, 1'b1);
    finished = 1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule